// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt front end of a small 8-bit CPU core. It accepts five hardware request sources:

- one non-maskable urgent request;
- three maskable requests with fixed vectors, named 7.5, 6.5 and 5.5;
- one general request, whose vector is supplied by the interrupting device.

When several sources are active in the same cycle, it picks one by fixed priority. It filters the maskable sources through a mask register and a global enable. It then presents a single request flag to the CPU, together with a 16-bit vector address.

Each fixed vector sits in the low 64 bytes of the address space, at a half step between two restart slots (slot number times eight, plus four). The CPU writes the mask register with a set-mask instruction and reads it back with a read-mask instruction. The read value also carries the pending state of the three maskable sources, the global enable and the level of a serial input pin. The CPU pulses acknowledge when it takes the interrupt that is being presented.

Top module: `vecIntCtrl`

## Requirements
- R1: After reset all three mask bits are 1, the global enable is 0, the 7.5 latch is clear and `irqOut` is 0, so `maskRdData` reads 0x07 with `serialIn` low.
- R2: While `trapReq` is high, `irqOut` is 1 and `vectorOut` is 0x0024, whatever the mask bits and the global enable hold.
- R3: Priority runs TRAP, then 7.5, then 6.5, then 5.5, then the general request; only the highest active eligible source is presented.
- R4: The vectors are 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5, with `extVector` 0. For the general request `vectorOut` is 0x0000 and `extVector` is 1.
- R5: A maskable source whose mask bit is 1 is not presented. When the global enable is 0, neither the maskable sources nor the general request are presented; the general request needs only the global enable.
- R6: A mask write with bit 3 set loads bits 2:0 into the masks (bit 0 for 5.5, bit 1 for 6.5, bit 2 for 7.5), effective from the next cycle. With bit 3 clear, the masks are unchanged.
- R7: A rising edge on `req75` sets the 7.5 latch, which stays set after the pin falls. A pin held high does not set it again. A mask write with bit 4 set clears it whatever bit 3 holds. A clear wins over an edge in the same cycle.
- R8: Sources 5.5 and 6.5 are level-sensitive and are presented only while their pin is high.
- R9: `maskRdData` has this layout: bits 2:0 are the masks, bit 3 is the global enable, bit 4 is the `req55` level, bit 5 is the `req65` level, bit 6 is the 7.5 latch, and bit 7 is `serialIn`.
- R10: `enableSet` sets the global enable and `enableClr` clears it. `ack` clears it and overrides a simultaneous `enableSet`.
- R11: `ack` clears the 7.5 latch only when 7.5 is the source being presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Non-maskable request, level |
| req75 | input | 1 | Maskable request 7.5, rising edge |
| req65 | input | 1 | Maskable request 6.5, level |
| req55 | input | 1 | Maskable request 5.5, level |
| genReq | input | 1 | General request, vector supplied externally |
| serialIn | input | 1 | Serial input pin reported in the read value |
| maskWrEn | input | 1 | Set-mask strobe |
| maskWrData | input | 8 | Set-mask byte |
| enableSet | input | 1 | Set the global enable |
| enableClr | input | 1 | Clear the global enable |
| ack | input | 1 | CPU acknowledge of the presented interrupt |
| irqOut | output | 1 | Interrupt request to the CPU |
| vectorOut | output | 16 | Vector address of the presented source |
| extVector | output | 1 | The presented source is the general request |
| maskRdData | output | 8 | Read-mask value |

## Verification
A wrong mask, enable or latch bit shows up in `maskRdData` in the very next cycle. On the request side it appears as a wrongly asserted or missing `irqOut`, or as a vector from the wrong source, as soon as a request that depends on that bit is active.

Because the 7.5 latch stays set until it is cleared, a missed edge, a spurious re-latch or a wrong clear on acknowledge remains visible in bit 6 for many cycles. The bench therefore compares every output against its reference model on every clock.

// File: rtl/vicPkg.sv
package vicPkg;
  localparam int VEC_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55, SRC_GEN
  } srcT;

  typedef struct packed {
    logic loadMask;
    logic clrLatch;
    logic setEn;
    logic clrEn;
  } ctlStrobeT;

  // Half-step restart vector: slot * 8 + 4
  function automatic logic [VEC_W-1:0] halfStepVec(input int slot);
    return VEC_W'(slot * 8 + 4);
  endfunction
endpackage

// File: rtl/vicControl.sv
module vicControl
  import vicPkg::*;
#(
  parameter int NUM_RST = 3
) (
  input  logic               trapReq,
  input  logic               req65,
  input  logic               req55,
  input  logic               genReq,
  input  logic [NUM_RST-1:0] maskBits,
  input  logic               globalEn,
  input  logic               latch75,
  input  logic               ack,
  input  logic               maskWrEn,
  input  logic [BYTE_W-1:0]  maskWrData,
  input  logic               enableSet,
  input  logic               enableClr,
  output srcT                src,
  output ctlStrobeT          ctl
);
  localparam int SET_BIT = NUM_RST;
  localparam int CLR_BIT = NUM_RST + 1;

  logic [NUM_RST-1:0] rstActive;  // index 0 = 5.5, 1 = 6.5, 2 = 7.5
  logic [NUM_RST-1:0] rstElig;

  assign rstActive = {latch75, req65, req55};

  genvar g;
  generate
    for (g = 0; g < NUM_RST; g++) begin : gElig
      assign rstElig[g] = rstActive[g] & ~maskBits[g] & globalEn;  // R5
    end
  endgenerate

  // R3: fixed priority
  always_comb begin
    src = SRC_NONE;
    if (trapReq)                src = SRC_TRAP;
    else if (rstElig[2])        src = SRC_R75;
    else if (rstElig[1])        src = SRC_R65;
    else if (rstElig[0])        src = SRC_R55;
    else if (genReq & globalEn) src = SRC_GEN;
  end

  always_comb begin
    ctl.loadMask = maskWrEn & maskWrData[SET_BIT];                                 // R6
    ctl.clrLatch = (maskWrEn & maskWrData[CLR_BIT]) | (ack & (src == SRC_R75));    // R7, R11
    ctl.clrEn    = ack | enableClr;                                                // R10
    ctl.setEn    = enableSet;
  end
endmodule

// File: rtl/vicDatapath.sv
module vicDatapath
  import vicPkg::*;
#(
  parameter int NUM_RST = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          ctl,
  input  srcT                src,
  input  logic               req75,
  input  logic               req65,
  input  logic               req55,
  input  logic               serialIn,
  input  logic [NUM_RST-1:0] newMask,
  output logic [NUM_RST-1:0] maskBits,
  output logic               globalEn,
  output logic               latch75,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vectorOut,
  output logic               extVector,
  output logic [BYTE_W-1:0]  maskRdData
);
  logic prev75;
  logic edge75;

  assign edge75 = req75 & ~prev75;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '1;  // R1
      globalEn <= 1'b0;
      latch75  <= 1'b0;
      prev75   <= 1'b0;
    end else begin
      prev75 <= req75;
      if (ctl.loadMask) maskBits <= newMask;
      if (ctl.clrEn)      globalEn <= 1'b0;
      else if (ctl.setEn) globalEn <= 1'b1;
      if (ctl.clrLatch)   latch75 <= 1'b0;  // clear wins (R7)
      else if (edge75)    latch75 <= 1'b1;
    end
  end

  // R4: vector selection
  always_comb begin
    vectorOut = '0;
    unique case (src)
      SRC_TRAP: vectorOut = halfStepVec(4);
      SRC_R55:  vectorOut = halfStepVec(5);
      SRC_R65:  vectorOut = halfStepVec(6);
      SRC_R75:  vectorOut = halfStepVec(7);
      default:  vectorOut = '0;
    endcase
  end

  assign irqOut    = (src != SRC_NONE);
  assign extVector = (src == SRC_GEN);

  // R9: read layout
  assign maskRdData = {serialIn, latch75, req65, req55, globalEn, maskBits};
endmodule

// File: rtl/vecIntCtrl.sv
module vecIntCtrl
  import vicPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic              req75,
  input  logic              req65,
  input  logic              req55,
  input  logic              genReq,
  input  logic              serialIn,
  input  logic              maskWrEn,
  input  logic [7:0]        maskWrData,
  input  logic              enableSet,
  input  logic              enableClr,
  input  logic              ack,
  output logic              irqOut,
  output logic [15:0]       vectorOut,
  output logic              extVector,
  output logic [7:0]        maskRdData
);
  localparam int NUM_RST = 3;

  ctlStrobeT          ctl;
  srcT                src;
  logic [NUM_RST-1:0] maskBits;
  logic               globalEn;
  logic               latch75;

  vicControl #(.NUM_RST(NUM_RST)) uCtl (
    .trapReq(trapReq), .req65(req65), .req55(req55), .genReq(genReq),
    .maskBits(maskBits), .globalEn(globalEn), .latch75(latch75),
    .ack(ack), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .enableSet(enableSet), .enableClr(enableClr),
    .src(src), .ctl(ctl)
  );

  vicDatapath #(.NUM_RST(NUM_RST)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .src(src),
    .req75(req75), .req65(req65), .req55(req55), .serialIn(serialIn),
    .newMask(maskWrData[NUM_RST-1:0]),
    .maskBits(maskBits), .globalEn(globalEn), .latch75(latch75),
    .irqOut(irqOut), .vectorOut(vectorOut), .extVector(extVector),
    .maskRdData(maskRdData)
  );
endmodule

// File: rtl/vecIntCtrlChk.sv
module vecIntCtrlChk (
  input logic        clk,
  input logic        rstN,
  input logic        trapReq,
  input logic        req75,
  input logic        maskWrEn,
  input logic [7:0]  maskWrData,
  input logic        ack,
  input logic        irqOut,
  input logic [15:0] vectorOut,
  input logic        extVector,
  input logic [7:0]  maskRdData
);
  // R2
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (irqOut && vectorOut == 16'h0024));

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !maskRdData[3]) |-> !irqOut);

  // R10
  ack_disables_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !maskRdData[3]);

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(maskWrEn && maskWrData[3]) |=> $stable(maskRdData[2:0]));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && maskWrData[3]) |=> (maskRdData[2:0] == $past(maskWrData[2:0])));

  // R7
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(req75) && !ack && !(maskWrEn && maskWrData[4])) |=> maskRdData[6]);

  // R7
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && maskWrData[4]) |=> !maskRdData[6]);

  // R4
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    extVector |-> (irqOut && vectorOut == 16'h0000));
endmodule

bind vecIntCtrl vecIntCtrlChk uChk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .req75(req75),
  .maskWrEn(maskWrEn), .maskWrData(maskWrData), .ack(ack),
  .irqOut(irqOut), .vectorOut(vectorOut), .extVector(extVector),
  .maskRdData(maskRdData)
);

// File: tb/test_vecIntCtrl.sv
`timescale 1ns/1ps
module test_vecIntCtrl;
  logic clk = 0, rstN = 0;
  logic trapReq = 0, req75 = 0, req65 = 0, req55 = 0, genReq = 0, serialIn = 0;
  logic maskWrEn = 0, enableSet = 0, enableClr = 0, ack = 0;
  logic [7:0] maskWrData = 0;
  logic irqOut, extVector;
  logic [15:0] vectorOut;
  logic [7:0] maskRdData;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // model state
  int mMask = 7, mEn = 0, mLatch = 0, mPrev = 0;

  always #4 clk = ~clk;

  vecIntCtrl i_vecIntCtrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .req75(req75), .req65(req65),
    .req55(req55), .genReq(genReq), .serialIn(serialIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .enableSet(enableSet), .enableClr(enableClr),
    .ack(ack), .irqOut(irqOut), .vectorOut(vectorOut), .extVector(extVector),
    .maskRdData(maskRdData)
  );

  // 0 none, 1 trap, 2 r75, 3 r65, 4 r55, 5 general
  function automatic int modelSel();
    if (trapReq) return 1;
    if (mEn == 1 && mLatch == 1 && !mMask[2]) return 2;
    if (mEn == 1 && req65 && !mMask[1]) return 3;
    if (mEn == 1 && req55 && !mMask[0]) return 4;
    if (mEn == 1 && genReq) return 5;
    return 0;
  endfunction

  function automatic int modelVec(int s);
    case (s)
      1: return 36;
      2: return 60;
      3: return 52;
      4: return 44;
      default: return 0;
    endcase
  endfunction

  function automatic int modelRd();
    return mMask + 8 * mEn + 16 * req55 + 32 * req65 + 64 * mLatch + 128 * serialIn;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 7; mEn = 0; mLatch = 0; mPrev = 0;
    end else begin
      int s;
      int clr;
      s = modelSel();
      clr = (maskWrEn && maskWrData[4]) || (ack && s == 2);
      if (clr) mLatch = 0;
      else if (req75 && mPrev == 0) mLatch = 1;
      mPrev = req75;
      if (maskWrEn && maskWrData[3]) mMask = maskWrData[2:0];
      if (ack || enableClr) mEn = 0;
      else if (enableSet) mEn = 1;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  task automatic compareAll();
    int s;
    s = modelSel();
    checkEq("R3 irqOut", irqOut, s != 0);
    checkEq("R4 vectorOut", vectorOut, modelVec(s));
    checkEq("R4 extVector", extVector, s == 5);
    checkEq("R9 maskRdData", maskRdData, modelRd());
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wrMask(logic [7:0] d);
    maskWrEn = 1; maskWrData = d;
    step();
    maskWrEn = 0; maskWrData = 0;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    checkEq("R1 reset read", maskRdData, 8'h07);
    checkEq("R1 reset irq", irqOut, 0);

    serialIn = 1; step();
    checkEq("R9 serial bit", maskRdData, 8'h87);

    trapReq = 1; step();
    checkEq("R2 trap irq", irqOut, 1);
    checkEq("R2 trap vec", vectorOut, 16'h0024);
    trapReq = 0;

    enableSet = 1; step(); enableSet = 0;
    checkEq("R10 enable set", maskRdData, 8'h8F);
    serialIn = 0;

    req55 = 1; step();
    checkEq("R5 masked 5.5", irqOut, 0);
    wrMask(8'h08);
    checkEq("R8 5.5 level vec", vectorOut, 16'h002C);
    checkEq("R9 read after unmask", maskRdData, 8'h18);

    wrMask(8'h07);
    checkEq("R6 no set-enable bit", maskRdData[2:0], 0);

    req65 = 1; step();
    checkEq("R3 6.5 over 5.5", vectorOut, 16'h0034);

    req75 = 1; step();
    checkEq("R7 edge latched", vectorOut, 16'h003C);
    req75 = 0; step();
    checkEq("R7 latch held", maskRdData[6], 1);

    genReq = 1; trapReq = 1; step();
    checkEq("R3 trap over all", vectorOut, 16'h0024);
    trapReq = 0;

    ack = 1; step(); ack = 0;
    checkEq("R10 ack clears enable", irqOut, 0);
    checkEq("R11 ack clears 7.5", maskRdData, 8'h30);

    enableSet = 1; step(); enableSet = 0;
    wrMask(8'h0C);
    req75 = 1; step();
    checkEq("R5 7.5 masked", vectorOut, 16'h0034);
    ack = 1; step(); ack = 0;
    checkEq("R11 latch kept", maskRdData, 8'h74);

    wrMask(8'h10);
    checkEq("R7 write clears latch", maskRdData, 8'h34);
    step();
    checkEq("R7 steady high no relatch", maskRdData[6], 0);

    req55 = 0; req65 = 0; req75 = 0;
    enableSet = 1; step(); enableSet = 0;
    checkEq("R4 general ext", extVector, 1);
    checkEq("R4 general vec", vectorOut, 16'h0000);

    ack = 1; enableSet = 1; step(); ack = 0; enableSet = 0;
    checkEq("R10 ack beats set", maskRdData[3], 0);
    enableSet = 1; step(); enableSet = 0;
    enableClr = 1; step(); enableClr = 0;
    checkEq("R10 enable clear", maskRdData[3], 0);

    wrMask(8'h08);
    req75 = 1; maskWrEn = 1; maskWrData = 8'h10; step();
    maskWrEn = 0; maskWrData = 0;
    checkEq("R7 clear beats edge", maskRdData[6], 0);
    req75 = 0; genReq = 0;

    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      trapReq   = (lfsr[3:0] == 0);
      req75     = lfsr[5];
      req65     = lfsr[6] & lfsr[1];
      req55     = lfsr[7];
      genReq    = lfsr[8];
      serialIn  = lfsr[9];
      maskWrEn  = (lfsr[12:10] == 0);
      maskWrData = {3'b0, lfsr[13], lfsr[14], lfsr[2:0]};
      enableSet = lfsr[11] & lfsr[15];
      enableClr = (lfsr[15:13] == 3'b111);
      ack       = irqOut & lfsr[4];
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule